// File: doc/BRIEF.md
# Per-hart interrupt delivery controller

This block sits between the wired interrupt sources of a platform and one hart that takes its external interrupts directly, without messages. Each source presents a pending-and-enabled flag, an 8-bit priority and the index of the hart it is routed to. The block keeps only the sources routed to its own hart and applies a threshold to them. It picks the most urgent one and drives the hart's external interrupt line. The line is gated by a global enable input and a per-hart delivery enable.

Software reaches the block through a 32-byte register window. The window holds a delivery enable, a force bit that raises the line by itself, and a priority threshold. It also has two read-only views of the current top interrupt. Reading the top view has no side effect. Reading the claim view returns the same word and sends a one-cycle clear strobe to the source side for that identity, so the handler can loop on claims until it reads zero. Pending state lives in the source gateways; the block never stores it.

Top module: `hart_irq_ctrl`

## Requirements
- R1: After reset, eip_o, rdata_o and clr_o are 0, and the delivery, force and threshold registers read 0.
- R2: Writes to offset 0x00 set delivery from wdata bit 0, to 0x04 set force from bit 0, and to 0x08 set the threshold from bits 7:0. Reads of these offsets return the stored value zero-extended. Read data appears on rdata_o one cycle after the request and holds until the next read.
- R3: A read of offset 0x18 returns the top interrupt with its identity in bits 25:16 and its effective priority in bits 7:0, or 0 if no source is eligible. Source 0 is never eligible. The top is the eligible source with the numerically lowest effective priority.
- R4: A priority of 0 counts as 1, and among equal effective priorities the lower source number wins.
- R5: With threshold 0 every priority passes. With a nonzero threshold only effective priorities strictly below it pass, so a threshold of 1 blocks all sources.
- R6: A source is eligible only when it is pending and its hart field equals the block's own hart index; other sources have no effect on any output.
- R7: A read of offset 0x1C returns the same word as 0x18. When that word is nonzero, clr_o pulses for one cycle together with the read data, and clr_id_o carries the returned identity.
- R8: A claim read with no eligible source returns 0, raises no clear strobe and resets force to 0.
- R9: eip_o is a registered output. It is 1 one cycle after glob_ie_i, delivery and (an eligible top or force) are all 1, and 0 otherwise.
- R10: Writes to offsets 0x18 and 0x1C change no register, and a read of 0x18 never pulses clr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glob_ie_i | input | 1 | Domain-wide interrupt enable |
| src_pend_i | input | NSRC | Pending-and-enabled flag per source |
| src_prio_i | input | NSRC*8 | Priority per source, source i in bits 8i+7:8i |
| src_hart_i | input | NSRC*HART_W | Target hart index per source |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 5 | Byte offset inside the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| clr_o | output | 1 | Clear-pending strobe from a claim |
| clr_id_o | output | $clog2(NSRC) | Source to clear |
| eip_o | output | 1 | External interrupt line to the hart |

## Verification
Read data and the clear strobe are both due one cycle after the request edge, so the bench raises a request on a falling edge and samples at the next falling edge. At that point the register file and the strobe have taken exactly one rising edge. The interrupt line takes one register, so it is due one edge after its inputs and two edges after a register write. The bench therefore checks it during the read that follows the configuration writes, when every contributing value has been stable for at least one edge. A claim's effect on force is checked with a separate read after the claim, and each cleared source is dropped from the bench's own pending set before the next step.

// File: rtl/hic_pkg.sv
package hic_pkg;
  localparam int PRIO_W   = 8;
  localparam int DATA_W   = 32;
  localparam int OFS_W    = 5;
  localparam int ID_LSB   = 16;
  localparam int ID_FLD_W = 10;

  localparam logic [OFS_W-1:0] OFS_DELIV  = 5'h00;
  localparam logic [OFS_W-1:0] OFS_FORCE  = 5'h04;
  localparam logic [OFS_W-1:0] OFS_THRESH = 5'h08;
  localparam logic [OFS_W-1:0] OFS_TOP    = 5'h18;
  localparam logic [OFS_W-1:0] OFS_CLAIM  = 5'h1C;
endpackage

// File: rtl/hic_src_elig.sv
module hic_src_elig import hic_pkg::*; #(
  parameter int NSRC      = 32,
  parameter int HART_W    = 14,
  parameter int THIS_HART = 0
) (
  input  logic [NSRC-1:0]        pend_i,
  input  logic [NSRC*PRIO_W-1:0] prio_i,
  input  logic [NSRC*HART_W-1:0] hart_i,
  input  logic [PRIO_W-1:0]      thresh_i,
  output logic [NSRC-1:0]        elig_o,
  output logic [NSRC*PRIO_W-1:0] eff_o
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic [PRIO_W-1:0] raw, eff;
    logic              hit, pass;
    assign raw  = prio_i[g*PRIO_W +: PRIO_W];
    // priority 0 is promoted to 1
    assign eff  = (raw == '0) ? PRIO_W'(1) : raw;
    assign hit  = hart_i[g*HART_W +: HART_W] == HART_W'(THIS_HART);
    assign pass = (thresh_i == '0) || (eff < thresh_i);
    assign eff_o[g*PRIO_W +: PRIO_W] = eff;
    // identity 0 means "none" and is never eligible
    assign elig_o[g] = (g != 0) && pend_i[g] && hit && pass;
  end
endmodule

// File: rtl/hic_top_arb.sv
module hic_top_arb import hic_pkg::*; #(
  parameter int NSRC = 32,
  parameter int ID_W = 5
) (
  input  logic [NSRC-1:0]        elig_i,
  input  logic [NSRC*PRIO_W-1:0] prio_i,
  output logic                   vld_o,
  output logic [ID_W-1:0]        id_o,
  output logic [PRIO_W-1:0]      prio_o
);
  // ascending scan, strict compare: ties keep the lower identity
  always_comb begin
    vld_o  = 1'b0;
    id_o   = '0;
    prio_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig_i[i] && (!vld_o || (prio_i[i*PRIO_W +: PRIO_W] < prio_o))) begin
        vld_o  = 1'b1;
        id_o   = ID_W'(i);
        prio_o = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/hic_regs.sv
module hic_regs import hic_pkg::*; #(
  parameter int ID_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [OFS_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              top_vld_i,
  input  logic [ID_W-1:0]   top_id_i,
  input  logic [PRIO_W-1:0] top_prio_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              deliv_o,
  output logic              force_o,
  output logic [PRIO_W-1:0] thresh_o,
  output logic              clr_o,
  output logic [ID_W-1:0]   clr_id_o
);
  logic              deliv_q, force_q, clr_q;
  logic [PRIO_W-1:0] thr_q;
  logic [DATA_W-1:0] rdata_q, top_word;
  logic [ID_W-1:0]   clr_id_q;
  logic              wdata_unused;

  assign wdata_unused = ^wdata_i[DATA_W-1:PRIO_W];

  always_comb begin
    top_word = '0;
    if (top_vld_i) begin
      top_word[ID_LSB +: ID_W]  = top_id_i;
      top_word[PRIO_W-1:0]      = top_prio_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      deliv_q  <= 1'b0;
      force_q  <= 1'b0;
      thr_q    <= '0;
      rdata_q  <= '0;
      clr_q    <= 1'b0;
      clr_id_q <= '0;
    end else begin
      clr_q <= 1'b0;
      if (req_i && we_i) begin
        case (addr_i)
          OFS_DELIV:  deliv_q <= wdata_i[0];
          OFS_FORCE:  force_q <= wdata_i[0];
          OFS_THRESH: thr_q   <= wdata_i[PRIO_W-1:0];
          default: ;
        endcase
      end
      if (req_i && !we_i) begin
        case (addr_i)
          OFS_DELIV:  rdata_q <= DATA_W'(deliv_q);
          OFS_FORCE:  rdata_q <= DATA_W'(force_q);
          OFS_THRESH: rdata_q <= DATA_W'(thr_q);
          OFS_TOP:    rdata_q <= top_word;
          OFS_CLAIM: begin
            rdata_q  <= top_word;
            clr_q    <= top_vld_i;
            clr_id_q <= top_id_i;
            if (!top_vld_i) force_q <= 1'b0;
          end
          default:    rdata_q <= '0;
        endcase
      end
    end
  end

  assign rdata_o  = rdata_q;
  assign deliv_o  = deliv_q;
  assign force_o  = force_q;
  assign thresh_o = thr_q;
  assign clr_o    = clr_q;
  assign clr_id_o = clr_id_q;

  // R8
  empty_claim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == OFS_CLAIM && !top_vld_i) |=> (rdata_o == '0 && !clr_o && !force_o));

  // R10
  top_read_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == OFS_TOP) |=> !clr_o);
endmodule

// File: rtl/hart_irq_ctrl.sv
module hart_irq_ctrl import hic_pkg::*; #(
  parameter int NSRC      = 32,
  parameter int HART_W    = 14,
  parameter int THIS_HART = 0,
  localparam int ID_W     = $clog2(NSRC)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   glob_ie_i,
  input  logic [NSRC-1:0]        src_pend_i,
  input  logic [NSRC*PRIO_W-1:0] src_prio_i,
  input  logic [NSRC*HART_W-1:0] src_hart_i,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [OFS_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic                   clr_o,
  output logic [ID_W-1:0]        clr_id_o,
  output logic                   eip_o
);
  logic [NSRC-1:0]        elig;
  logic [NSRC*PRIO_W-1:0] eff;
  logic                   top_vld, deliv, force_b, eip_q;
  logic [ID_W-1:0]        top_id;
  logic [PRIO_W-1:0]      top_prio, thresh;

  hic_src_elig #(.NSRC(NSRC), .HART_W(HART_W), .THIS_HART(THIS_HART)) u_elig (
    .pend_i(src_pend_i), .prio_i(src_prio_i), .hart_i(src_hart_i),
    .thresh_i(thresh), .elig_o(elig), .eff_o(eff));

  hic_top_arb #(.NSRC(NSRC), .ID_W(ID_W)) u_arb (
    .elig_i(elig), .prio_i(eff),
    .vld_o(top_vld), .id_o(top_id), .prio_o(top_prio));

  hic_regs #(.ID_W(ID_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i),
    .top_vld_i(top_vld), .top_id_i(top_id), .top_prio_i(top_prio),
    .rdata_o(rdata_o), .deliv_o(deliv), .force_o(force_b), .thresh_o(thresh),
    .clr_o(clr_o), .clr_id_o(clr_id_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eip_q <= 1'b0;
    else         eip_q <= glob_ie_i && deliv && (top_vld || force_b);
  end
  assign eip_o = eip_q;

  // R3
  top_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_vld |-> (src_pend_i[top_id] && top_id != '0 && top_prio != '0));

  // R5
  thresh_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_vld |-> (thresh == '0 || top_prio < thresh));

  // R7
  clr_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |-> (rdata_o[ID_LSB +: ID_FLD_W] == ID_FLD_W'(clr_id_o) && clr_id_o != '0));

  // R9
  eip_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eip_o |-> ($past(glob_ie_i) && $past(deliv)));

  // R9
  eip_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glob_ie_i && deliv && force_b) |=> eip_o);
endmodule

// File: tb/hart_irq_ctrl_tb_top.sv
module hart_irq_ctrl_tb_top;
  localparam int NSRC = 8;
  localparam int HW   = 4;
  localparam int ME   = 3;
  localparam int IDW  = $clog2(NSRC);

  logic            clk = 1'b0, rst_ni = 1'b0, gie = 1'b0;
  logic [NSRC-1:0] pend = '0;
  logic [7:0]      prio_a [NSRC];
  logic [HW-1:0]   hart_a [NSRC];
  logic [NSRC*8-1:0]  prio_f;
  logic [NSRC*HW-1:0] hart_f;
  logic            req = 1'b0, we = 1'b0;
  logic [4:0]      addr = '0;
  logic [31:0]     wdata = '0, rdata;
  logic            clr, eip;
  logic [IDW-1:0]  clr_id;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always_comb
    for (int i = 0; i < NSRC; i++) begin
      prio_f[i*8 +: 8]   = prio_a[i];
      hart_f[i*HW +: HW] = hart_a[i];
    end

  hart_irq_ctrl #(.NSRC(NSRC), .HART_W(HW), .THIS_HART(ME)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .glob_ie_i(gie), .src_pend_i(pend),
    .src_prio_i(prio_f), .src_hart_i(hart_f), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .clr_o(clr),
    .clr_id_o(clr_id), .eip_o(eip));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=0x%08h exp=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  // bench view of the top interrupt, from the requirements
  function automatic logic [31:0] model(input logic [7:0] thr);
    int best = 0, bp = 0;
    for (int i = 1; i < NSRC; i++) begin
      int e = (prio_a[i] == 0) ? 1 : int'(prio_a[i]);
      if (pend[i] && hart_a[i] == HW'(ME) && (thr == 0 || e < int'(thr)) && (best == 0 || e < bp)) begin
        best = i; bp = e;
      end
    end
    return (best == 0) ? 32'h0 : ((32'(best) << 16) | 32'(bp));
  endfunction

  task automatic clear_src;
    for (int i = 0; i < NSRC; i++) begin prio_a[i] = 8'd0; hart_a[i] = HW'(ME); end
    pend = '0;
  endtask

  task automatic top_case(input string tag, input logic [7:0] thr, input logic [31:0] exp);
    logic [31:0] d;
    rd(5'h18, d);
    chk(d == exp && d == model(thr), tag, d, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all-requirements act=0x%08h exp=0x%08h", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, exp, r = 32'h1234_5678;
    bit dl, fc;
    logic [7:0] thr;
    clear_src();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(eip == 0 && rdata == 0 && clr == 0, "R1 outputs", {29'd0, eip, clr, |rdata}, 0);
    rd(5'h00, d); chk(d == 0, "R1 delivery", d, 0);
    rd(5'h04, d); chk(d == 0, "R1 force", d, 0);
    rd(5'h08, d); chk(d == 0, "R1 threshold", d, 0);

    // R2 register fields
    wr(5'h08, 32'hFFFF_FF05); rd(5'h08, d); chk(d == 32'h5, "R2 threshold bits", d, 32'h5);
    wr(5'h00, 32'hFFFF_FFFE); rd(5'h00, d); chk(d == 0, "R2 delivery bit0", d, 0);
    wr(5'h00, 32'h1);         rd(5'h00, d); chk(d == 1, "R2 delivery set", d, 1);
    wr(5'h04, 32'h3);         rd(5'h04, d); chk(d == 1, "R2 force set", d, 1);
    @(negedge clk);           chk(rdata == 1, "R2 rdata holds", rdata, 1);
    wr(5'h04, 32'h0);

    // R10 writes to read-only views
    wr(5'h18, 32'hFFFF_FFFF); wr(5'h1C, 32'hFFFF_FFFF);
    chk(clr == 0, "R10 no strobe on write", {31'd0, clr}, 0);
    rd(5'h00, d); chk(d == 1, "R10 delivery kept", d, 1);
    rd(5'h04, d); chk(d == 0, "R10 force kept", d, 0);
    rd(5'h08, d); chk(d == 5, "R10 threshold kept", d, 5);
    wr(5'h08, 32'h0);

    // R4 ties and priority 0
    clear_src(); gie = 1'b1;
    prio_a[2] = 3; prio_a[5] = 3; pend = 8'b0010_0100;
    top_case("R4 tie lower id", 0, 32'h0002_0003);
    prio_a[6] = 0; prio_a[4] = 1; pend = 8'b0101_0000;
    top_case("R4 prio0 as 1 tie", 0, 32'h0004_0001);
    // R3 source 0 never selected
    clear_src(); pend = 8'b0000_0001;
    top_case("R3 source 0", 0, 0);
    // R6 other hart ignored
    prio_a[1] = 1; hart_a[1] = 2; prio_a[7] = 9; pend = 8'b1000_0010;
    top_case("R6 foreign hart", 0, 32'h0007_0009);
    // R5 threshold
    clear_src(); prio_a[3] = 4; pend = 8'b0000_1000;
    wr(5'h08, 32'h1); top_case("R5 thr1 blocks", 1, 0);
    wr(5'h08, 32'h4); top_case("R5 equal blocked", 4, 0);
    wr(5'h08, 32'h5); top_case("R5 below passes", 5, 32'h0003_0004);
    wr(5'h08, 32'h0);

    // R9 gating
    @(negedge clk); chk(eip == 1, "R9 pending delivered", {31'd0, eip}, 1);
    gie = 1'b0; @(negedge clk); chk(eip == 0, "R9 global off", {31'd0, eip}, 0);
    gie = 1'b1; pend = '0; wr(5'h04, 1); @(negedge clk);
    chk(eip == 1, "R9 force alone", {31'd0, eip}, 1);
    wr(5'h00, 0); @(negedge clk); chk(eip == 0, "R9 delivery off", {31'd0, eip}, 0);
    // R8 empty claim clears force
    rd(5'h1C, d); chk(d == 0 && clr == 0, "R8 empty claim", {d[30:0], clr}, 0);
    rd(5'h04, d); chk(d == 0, "R8 force cleared", d, 0);

    // sweep
    for (int it = 0; it < 500; it++) begin
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      dl = r[31] | r[30]; fc = r[29] & r[28]; gie = ~(r[27] & r[26]);
      thr = 8'(it % 9);
      wr(5'h00, {31'd0, dl}); wr(5'h04, {31'd0, fc}); wr(5'h08, {24'd0, thr});
      pend = r[7:0];
      for (int i = 0; i < NSRC; i++) begin
        prio_a[i] = 8'((r >> (i * 3 + 8)) & 7);
        hart_a[i] = r[(i + 3) % 32] ? HW'(ME) : HW'(5);
      end
      exp = model(thr);
      rd(5'h18, d);
      chk(d == exp, "R3 sweep top", d, exp);
      chk(clr == 0, "R10 top read no strobe", {31'd0, clr}, 0);
      chk(eip == (gie && dl && (exp != 0 || fc)), "R9 sweep eip", {31'd0, eip},
          {31'd0, gie && dl && (exp != 0 || fc)});
      rd(5'h1C, d);
      chk(d == exp, "R7 claim word", d, exp);
      chk(clr == (exp != 0) && (exp == 0 || 32'(clr_id) == exp[25:16]), "R7 clear strobe",
          {clr, 28'd0, clr_id}, {(exp != 0), 28'd0, IDW'(exp[25:16])});
      if (clr) pend[clr_id] = 1'b0;
      rd(5'h04, d);
      chk(d == ((exp != 0) ? {31'd0, fc} : 32'd0), "R8 force after claim", d,
          (exp != 0) ? {31'd0, fc} : 32'd0);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule